// File: doc/BRIEF.md
# Two-Wire Register Target with Pointer Wrap

This block is the target side of a two-wire serial control bus (I2C-style, up to 400 kbit/s) in front of a bank of 8-bit control registers. It is clocked by a fast system clock. It synchronises the SCL and SDA lines, finds start and stop conditions, and shifts bytes in on SCL rising edges. It answers with an acknowledge by pulling SDA low during the ninth clock. Its 7-bit bus address comes from a strap pin. A low strap selects 0x33 and a high strap selects 0x36.

A write transfer carries the device address, then a register address byte, then any number of data bytes. Each data byte is stored in the bank and is also shown for one system clock on a write port. A read returns bytes from the current register pointer. The pointer can first be set by a write transfer, either one ended by a stop or one followed by a repeated start. After every data byte the pointer moves forward by one. Past the last register, 0x6C, it goes back to 0x00.

The controller has ten states:
- ST_IDLE: waits for a start.
- ST_RX_DEV: shifts in the address byte.
- ST_ACK_DEV: acknowledges the address.
- ST_RX_REG: shifts in the register address.
- ST_ACK_REG: acknowledges the register address.
- ST_RX_WDATA: shifts in a write byte.
- ST_ACK_WDATA: acknowledges the write byte.
- ST_TX_DATA: drives a read byte.
- ST_RX_MACK: samples the master's acknowledge.
- ST_IGNORE: leaves the bus alone.

The transitions are:
- Start, from any state: to ST_RX_DEV.
- Stop, from any state: to ST_IDLE.
- ST_RX_DEV, byte complete and address matches: to ST_ACK_DEV.
- ST_RX_DEV, byte complete and address does not match: to ST_IGNORE.
- ST_ACK_DEV, ack clock ends: to ST_TX_DATA for a read, or ST_RX_REG for a write.
- ST_RX_REG, byte complete: to ST_ACK_REG.
- ST_ACK_REG, ack clock ends: to ST_RX_WDATA.
- ST_RX_WDATA, byte complete: to ST_ACK_WDATA.
- ST_ACK_WDATA, ack clock ends: back to ST_RX_WDATA.
- ST_TX_DATA, byte complete: to ST_RX_MACK.
- ST_RX_MACK, ack clock ends: to ST_TX_DATA if the master acknowledged, or ST_IGNORE if it did not.

Top module: `tw_reg_target`

## Requirements
- R1: The address byte is matched against 0x33 when `addr_sel_i` is 0 and 0x36 when it is 1. The address sits in bits 7:1 and bit 0 is 1 for read. A match is acknowledged by SDA held low through the ninth SCL high phase.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start in any state, even in the middle of a byte, begins a new address byte. Back-to-back starts and back-to-back stops leave the next transfer working.
- R3: The block changes its SDA drive only while SCL is low. It samples SDA on SCL rising edges, so the value it drives stays constant through each SCL high phase.
- R4: The register address byte and every write data byte are each acknowledged in their ninth clock.
- R5: In a write, the byte after the register address is stored at the pointer. Each stored byte raises `wr_en_o` for exactly one system clock, with `wr_addr_o` and `wr_data_o` holding the pointer and the byte.
- R6: The pointer advances by one after each completed data byte, in both writes and reads. After 0x6C it becomes 0x00.
- R7: A pointer above 0x6C is still acknowledged. A data byte written there produces no write pulse and changes no register. A read there returns 0x00. The next pointer after such a value is 0x00.
- R8: A read address byte returns bytes MSB first starting at the pointer. This holds after a repeated start that follows the register address, and also in a fresh transfer after the pointer was set in an earlier one.
- R9: A master acknowledge (SDA low in the ninth clock) continues the read with the next register. A master non-acknowledge ends the read, and SDA stays released until the next start.
- R10: An address byte that does not match is not acknowledged. No write happens and SDA stays released until the next start or stop.
- R11: After reset, SDA is released, `wr_en_o` is 0, every register reads 0x00 and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 1 | Strap choosing the bus address (0: 0x33, 1: 0x36) |
| sda_pull_o | output | 1 | When 1, the data line is pulled low |
| wr_en_o | output | 1 | One-cycle strobe for each stored byte |
| wr_addr_o | output | 8 | Register address of the stored byte |
| wr_data_o | output | 8 | Value of the stored byte |

## Verification
A wrong state or bit count in the controller shows at the ports within one byte. It appears as a missing or misplaced acknowledge in the ninth clock, or as SDA driven during a clock it should not touch. A pointer that is wrong after a wrap, or a wrong out-of-range decision, shows only on the next data byte: either in the address on the write port, or as wrong read-back data. Burst and wrap sequences therefore compare every byte, not only the first one. Bad start or stop handling shows in the following transfer, so each condition test is followed by a complete write and a read-back.

// File: rtl/tw_reg_pkg.sv
package tw_reg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RX_DEV,
        ST_ACK_DEV,
        ST_RX_REG,
        ST_ACK_REG,
        ST_RX_WDATA,
        ST_ACK_WDATA,
        ST_TX_DATA,
        ST_RX_MACK,
        ST_IGNORE
    } tw_state_t;

    // Line events, each valid for a single system clock.
    typedef struct packed {
        logic scl_high;
        logic scl_rise;
        logic scl_fall;
        logic sda;
        logic start;
        logic stop;
    } tw_bus_ev_t;

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync
    import tw_reg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output tw_bus_ev_t ev_o
);

    logic [STAGES-1:0] scl_sync;
    logic [STAGES-1:0] sda_sync;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_now;
    logic              sda_now;

    generate
        if (STAGES > 1) begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= {scl_sync[STAGES-2:0], scl_i};
                    sda_sync <= {sda_sync[STAGES-2:0], sda_i};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= scl_i;
                    sda_sync <= sda_i;
                end
            end
        end
    endgenerate

    assign scl_now = scl_sync[STAGES-1];
    assign sda_now = sda_sync[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_now;
            sda_prev <= sda_now;
        end
    end

    always_comb begin
        ev_o.scl_high = scl_now;
        ev_o.scl_rise = scl_now & ~scl_prev;
        ev_o.scl_fall = ~scl_now & scl_prev;
        ev_o.sda      = sda_now;
        ev_o.start    = scl_now & scl_prev & sda_prev & ~sda_now;
        ev_o.stop     = scl_now & scl_prev & ~sda_prev & sda_now;
    end

endmodule

// File: rtl/tw_ptr_ctrl.sv
module tw_ptr_ctrl #(
    parameter int            AW   = 8,
    parameter logic [AW-1:0] LAST = 8'h6C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] load_val_i,
    input  logic          step_i,
    output logic [AW-1:0] ptr_o,
    output logic          in_range_o
);

    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load_i) begin
            ptr_q <= load_val_i;
        end else if (step_i) begin
            // Anything at or beyond the top register folds back to zero.
            ptr_q <= (ptr_q >= LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    assign ptr_o      = ptr_q;
    assign in_range_o = (ptr_q <= LAST);

    // Loading and stepping come from different bytes of a transfer.
    assert_load_step_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && step_i));

endmodule

// File: rtl/tw_regbank.sv
module tw_regbank #(
    parameter int            AW   = 8,
    parameter int            DW   = 8,
    parameter logic [AW-1:0] LAST = 8'h6C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o
);

    localparam int DEPTH = int'(LAST) + 1;
    localparam int IDXW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] regs [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                regs[i] <= '0;
            end
        end else if (wr_en_i && (wr_addr_i <= LAST)) begin
            regs[wr_addr_i[IDXW-1:0]] <= wr_data_i;
        end
    end

    assign rd_data_o = (rd_addr_i <= LAST) ? regs[rd_addr_i[IDXW-1:0]] : '0;

endmodule

// File: rtl/tw_reg_target.sv
module tw_reg_target
    import tw_reg_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 8,
    parameter int                DEV_W       = 7,
    parameter logic [ADDR_W-1:0] LAST_REG    = 8'h6C,
    parameter logic [DEV_W-1:0]  DEV_ADDR_LO = 7'h33,
    parameter logic [DEV_W-1:0]  DEV_ADDR_HI = 7'h36,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_sel_i,
    output logic              sda_pull_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] BYTE_BITS = CNT_W'(DATA_W);

    tw_bus_ev_t        ev;
    tw_state_t         state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] tx_q;
    logic              rw_q;
    logic              mack_q;
    logic [ADDR_W-1:0] ptr;
    logic              ptr_in_range;
    logic [DATA_W-1:0] rd_data;
    logic [DEV_W-1:0]  own_addr;
    logic              byte_fall;
    logic              dev_match;
    logic              rx_active;
    logic              ptr_load;
    logic              ptr_step;
    logic              wr_req;

    tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    assign own_addr  = addr_sel_i ? DEV_ADDR_HI : DEV_ADDR_LO;
    assign byte_fall = ev.scl_fall && (bit_cnt_q == BYTE_BITS);
    assign dev_match = (rx_q[DATA_W-1 -: DEV_W] == own_addr);
    assign rx_active = (state_q == ST_RX_DEV) || (state_q == ST_RX_REG) ||
                       (state_q == ST_RX_WDATA);

    assign ptr_load = (state_q == ST_RX_REG) && byte_fall;
    assign ptr_step = byte_fall && ((state_q == ST_RX_WDATA) || (state_q == ST_TX_DATA));
    assign wr_req   = (state_q == ST_RX_WDATA) && byte_fall && ptr_in_range;

    tw_ptr_ctrl #(.AW(ADDR_W), .LAST(LAST_REG)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ptr_load),
        .load_val_i (rx_q[ADDR_W-1:0]),
        .step_i     (ptr_step),
        .ptr_o      (ptr),
        .in_range_o (ptr_in_range)
    );

    tw_regbank #(.AW(ADDR_W), .DW(DATA_W), .LAST(LAST_REG)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_req),
        .wr_addr_i (ptr),
        .wr_data_i (rx_q),
        .rd_addr_i (ptr),
        .rd_data_o (rd_data)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (ev.start) begin
            state_d = ST_RX_DEV;
        end else if (ev.stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_IGNORE:    state_d = ST_IGNORE;
                ST_RX_DEV:    if (byte_fall) state_d = dev_match ? ST_ACK_DEV : ST_IGNORE;
                ST_ACK_DEV:   if (ev.scl_fall) state_d = rw_q ? ST_TX_DATA : ST_RX_REG;
                ST_RX_REG:    if (byte_fall) state_d = ST_ACK_REG;
                ST_ACK_REG:   if (ev.scl_fall) state_d = ST_RX_WDATA;
                ST_RX_WDATA:  if (byte_fall) state_d = ST_ACK_WDATA;
                ST_ACK_WDATA: if (ev.scl_fall) state_d = ST_RX_WDATA;
                ST_TX_DATA:   if (byte_fall) state_d = ST_RX_MACK;
                ST_RX_MACK:   if (ev.scl_fall) state_d = mack_q ? ST_TX_DATA : ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Bit counter, shifters and the read/write flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            rx_q      <= '0;
            tx_q      <= '0;
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
        end else begin
            if (ev.start || (state_d != state_q)) begin
                bit_cnt_q <= '0;
            end else if (ev.scl_rise && (rx_active || (state_q == ST_TX_DATA))) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end

            if (ev.scl_rise && rx_active) begin
                rx_q <= {rx_q[DATA_W-2:0], ev.sda};
            end

            if ((state_q == ST_RX_DEV) && byte_fall) begin
                rw_q <= rx_q[0];
            end

            if (ev.scl_rise && (state_q == ST_RX_MACK)) begin
                mack_q <= ~ev.sda;
            end

            if ((state_q != ST_TX_DATA) && (state_d == ST_TX_DATA)) begin
                tx_q <= rd_data;
            end else if ((state_q == ST_TX_DATA) && ev.scl_fall && !byte_fall) begin
                tx_q <= {tx_q[DATA_W-2:0], 1'b0};
            end
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull_o <= 1'b0;
            wr_en_o    <= 1'b0;
            wr_addr_o  <= '0;
            wr_data_o  <= '0;
        end else begin
            unique case (state_q)
                ST_ACK_DEV, ST_ACK_REG, ST_ACK_WDATA: sda_pull_o <= 1'b1;
                ST_TX_DATA:                           sda_pull_o <= ~tx_q[DATA_W-1];
                default:                              sda_pull_o <= 1'b0;
            endcase
            wr_en_o <= wr_req;
            if (wr_req) begin
                wr_addr_o <= ptr;
                wr_data_o <= rx_q;
            end
        end
    end

    // The data line drive moves only while the clock line is low.
    assert_sda_moves_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o != $past(sda_pull_o)) |-> !ev.scl_high);

    // Each stored byte gives a strobe that lasts one cycle.
    assert_wr_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);

    // A write to the top register leaves the pointer at zero.
    assert_wrap_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && (wr_addr_o == LAST_REG)) |-> (ptr == '0));

    // No strobe names an address beyond the bank.
    assert_wr_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_addr_o <= LAST_REG));

    // Once the bus is being ignored, the line stays released.
    assert_ignore_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IGNORE) && ($past(state_q) == ST_IGNORE)) |-> !sda_pull_o);

endmodule

// File: tb/tw_reg_target_tb_top.sv
`timescale 1ns/1ps
module tw_reg_target_tb_top;

    localparam int          H      = 8;
    localparam logic [6:0]  DEV_LO = 7'h33;
    localparam logic [6:0]  DEV_HI = 7'h36;
    localparam int          NVEC   = 6;
    // {register address, data}
    localparam logic [15:0] VEC_TAB [NVEC] = '{
        16'h00A5, 16'h013C, 16'h10FF, 16'h6B81, 16'h6C5A, 16'h2F00
    };

    logic clk = 1'b0;
    logic rst_n;
    logic m_scl, m_sda, addr_sel;
    logic sda_pull, wr_en;
    logic [7:0] wr_addr, wr_data;
    logic sda_bus;

    always #2.5 clk = ~clk;
    assign sda_bus = m_sda & ~sda_pull;

    tw_reg_target dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .addr_sel_i (addr_sel),
        .sda_pull_o (sda_pull),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data)
    );

    int checks = 0;
    int errors = 0;
    int r3_viol = 0;
    int wcnt = 0;
    logic [7:0] wl_addr [64];
    logic [7:0] wl_data [64];
    logic [7:0] exp_mem [109];

    always @(negedge clk) begin
        if (wr_en) begin
            wl_addr[wcnt % 64] = wr_addr;
            wl_data[wcnt % 64] = wr_data;
            wcnt++;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        m_scl = 1'b0; tick(H);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b1; tick(H);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;    tick(H);
        m_scl = 1'b1; tick(H);
        m_scl = 1'b0; tick(H);
    endtask

    task automatic recv_bit(output logic b);
        logic b2;
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H/2);
        b = sda_bus;  tick(H/2);
        b2 = sda_bus;
        if (b2 !== b) r3_viol++;
        m_scl = 1'b0; tick(H);
    endtask

    task automatic wb(input logic [7:0] v, output bit ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        ack = (a == 1'b0);
    endtask

    task automatic rb(input bit mack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(mack ? 1'b0 : 1'b1);
    endtask

    task automatic reg_read1(input logic [7:0] ra, output logic [7:0] d);
        bit a;
        bus_start(); wb({DEV_LO, 1'b0}, a); wb(ra, a);
        bus_start(); wb({DEV_LO, 1'b1}, a); rb(1'b0, d);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit a1, a2, a3, a4;
        int base;
        logic [7:0] d, d2;

        for (int i = 0; i < 109; i++) exp_mem[i] = 8'h00;
        m_scl = 1'b1; m_sda = 1'b1; addr_sel = 1'b0; rst_n = 1'b0;
        tick(5);
        check(sda_pull == 1'b0 && wr_en == 1'b0, "R11 reset outputs", {14'd0, sda_pull, wr_en}, 16'h0000);
        rst_n = 1'b1;
        tick(5);

        // R11: the bank reads zero and the pointer starts at zero
        bus_start(); wb({DEV_LO, 1'b1}, a1); rb(1'b0, d); bus_stop();
        check(a1, "R1 address 0x33 acknowledged with strap low", {15'd0, a1}, 16'h0001);
        check(d == 8'h00, "R11 first read after reset", {8'd0, d}, 16'h0000);

        // Table walk: single write, then combined read-back (R4 R5 R8)
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] ra, dv;
            ra = VEC_TAB[v][15:8];
            dv = VEC_TAB[v][7:0];
            base = wcnt;
            bus_start(); wb({DEV_LO, 1'b0}, a1); wb(ra, a2); wb(dv, a3); bus_stop();
            exp_mem[ra] = dv;
            check(a1 && a2 && a3, "R4 write acknowledges", {13'd0, a1, a2, a3}, 16'h0007);
            check(wcnt == base + 1 && wl_addr[base % 64] == ra && wl_data[base % 64] == dv,
                  "R5 write strobe", {wl_addr[base % 64], wl_data[base % 64]}, {ra, dv});
            reg_read1(ra, d);
            check(d == dv, "R8 combined read-back", {8'd0, d}, {8'd0, dv});
        end

        // R6: burst write across the top register
        base = wcnt;
        bus_start(); wb({DEV_LO, 1'b0}, a1); wb(8'h6B, a1);
        wb(8'h11, a2); wb(8'h22, a3); wb(8'h33, a4); bus_stop();
        exp_mem[8'h6B] = 8'h11; exp_mem[8'h6C] = 8'h22; exp_mem[8'h00] = 8'h33;
        check(wcnt == base + 3, "R6 burst strobe count", wcnt - base, 16'd3);
        check(wl_addr[(base + 1) % 64] == 8'h6C && wl_addr[(base + 2) % 64] == 8'h00 &&
              wl_data[(base + 2) % 64] == 8'h33,
              "R6 wrap 6C to 00 on write", {wl_addr[(base + 2) % 64], wl_data[(base + 2) % 64]}, 16'h0033);

        // R6 R9: burst read across the wrap, acknowledging the first byte
        bus_start(); wb({DEV_LO, 1'b0}, a1); wb(8'h6C, a1);
        bus_start(); wb({DEV_LO, 1'b1}, a1); rb(1'b1, d); rb(1'b0, d2); bus_stop();
        check(d == 8'h22 && d2 == 8'h33, "R9 ack continues read, R6 read wrap", {d, d2}, 16'h2233);

        // R8: current-address read in a new transfer
        bus_start(); wb({DEV_LO, 1'b0}, a1); wb(8'h01, a1); bus_stop();
        bus_start(); wb({DEV_LO, 1'b1}, a1); rb(1'b0, d); bus_stop();
        check(d == exp_mem[1], "R8 current-address read", {8'd0, d}, {8'd0, exp_mem[1]});

        // R7: out-of-range pointer
        base = wcnt;
        bus_start(); wb({DEV_LO, 1'b0}, a1); wb(8'h70, a2); wb(8'h99, a3); bus_stop();
        check(a2 && a3, "R7 out-of-range bytes acknowledged", {14'd0, a2, a3}, 16'h0003);
        check(wcnt == base, "R7 no strobe out of range", wcnt - base, 16'd0);
        bus_start(); wb({DEV_LO, 1'b0}, a1); wb(8'h70, a1);
        bus_start(); wb({DEV_LO, 1'b1}, a1); rb(1'b1, d); rb(1'b0, d2); bus_stop();
        check(d == 8'h00 && d2 == exp_mem[0], "R7 read out of range then 00", {d, d2}, {8'h00, exp_mem[0]});

        // R9: after NACK the line stays released for further clocks
        bus_start(); wb({DEV_LO, 1'b1}, a1); rb(1'b0, d);
        check(d == exp_mem[1], "R9 read before nack", {8'd0, d}, {8'd0, exp_mem[1]});
        rb(1'b0, d2); bus_stop();
        check(d2 == 8'hFF, "R9 released after nack", {8'd0, d2}, 16'h00FF);

        // R10: wrong address ignored
        base = wcnt;
        bus_start(); wb({DEV_HI, 1'b0}, a1); wb(8'h02, a2); wb(8'h55, a3); bus_stop();
        check(!a1 && !a2 && !a3, "R10 no acknowledge on mismatch", {13'd0, a1, a2, a3}, 16'h0000);
        check(wcnt == base, "R10 no write on mismatch", wcnt - base, 16'd0);
        reg_read1(8'h02, d);
        check(d == exp_mem[2], "R10 register untouched", {8'd0, d}, {8'd0, exp_mem[2]});

        // R1: strap high selects 0x36
        addr_sel = 1'b1; tick(H);
        bus_start(); wb({DEV_HI, 1'b0}, a1); wb(8'h02, a2); wb(8'h77, a3); bus_stop();
        exp_mem[2] = 8'h77;
        check(a1 && a2 && a3, "R1 address 0x36 acknowledged with strap high", {13'd0, a1, a2, a3}, 16'h0007);
        bus_start(); wb({DEV_LO, 1'b0}, a1); bus_stop();
        check(!a1, "R1 address 0x33 refused with strap high", {15'd0, a1}, 16'h0000);
        addr_sel = 1'b0; tick(H);
        reg_read1(8'h02, d);
        check(d == 8'h77, "R1 write through high strap", {8'd0, d}, 16'h0077);

        // R2: back-to-back starts and stops
        base = wcnt;
        bus_start(); bus_start();
        wb({DEV_LO, 1'b0}, a1); wb(8'h20, a2); wb(8'hC3, a3);
        bus_stop(); bus_stop();
        exp_mem[8'h20] = 8'hC3;
        check(a1 && a2 && a3 && wcnt == base + 1 && wl_data[base % 64] == 8'hC3,
              "R2 repeated start and stop", {8'd0, wl_data[base % 64]}, 16'h00C3);

        // R2: start in the middle of a byte restarts the address byte
        base = wcnt;
        bus_start(); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_start(); wb({DEV_LO, 1'b0}, a1); wb(8'h21, a2); wb(8'h4E, a3); bus_stop();
        exp_mem[8'h21] = 8'h4E;
        check(a1 && wcnt == base + 1 && wl_addr[base % 64] == 8'h21,
              "R2 start mid-byte", {8'd0, wl_addr[base % 64]}, 16'h0021);
        reg_read1(8'h21, d);
        check(d == 8'h4E, "R2 data after mid-byte start", {8'd0, d}, 16'h004E);

        check(r3_viol == 0, "R3 SDA steady while SCL high", r3_viol, 16'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule